// File: doc/BRIEF.md
# Elastic Fall-Through FIFO Register

This block is a first-in-first-out buffer built as a chain of word stages rather than as an addressed memory. Each stage holds one data word and a one-bit occupancy marker. On every clock edge, a stage that is vacant copies the word from an occupied stage just upstream of it. The upstream stage then becomes vacant. Occupied slots therefore drift toward the output end and vacant slots drift back toward the input end, one stage per clock.

A producer presents a word together with a write strobe while the input-ready flag is high. A consumer sees the output-ready flag rise once a word has reached the last stage. It takes that word by pulsing the read strobe. An output-enable input either drives the word at the output end onto the data pins or leaves them floating. A word written into an empty chain needs depth minus one clocks to reach the output. Input-ready reflects only the first stage, so it also drops for a cycle while a freshly written word leaves that stage.

Depth and word width are parameters. The defaults are 16 stages of 4 bits. The depth must be at least 2. The active-low reset is asynchronous on assertion. It is expected to be released in step with the clock.

Top module: `elastic_chain_fifo`

## Requirements
- R1: While rst_n is low, every occupancy marker is cleared, so in_ready reads 1 and out_ready reads 0. This holds also when reset is asserted in mid-operation.
- R2: A write (wr_en=1 while in_ready=1) is captured on the clock edge. From that edge until the word moves on, the first stage is occupied and in_ready reads 0.
- R3: A write while in_ready=0 is ignored: the word never appears at the output, and the first stage's contents are unchanged.
- R4: A word advances exactly one stage per clock while the next stage is vacant. After a write into an empty FIFO, out_ready rises DEPTH-1 clock edges after the write edge.
- R5: Words leave in exactly the order in which their writes were accepted, with their values unchanged.
- R6: A read (rd_en=1 while out_ready=1) removes the word from the last stage on that edge, so out_ready is 0 in the following cycle.
- R7: A read while out_ready=0 is ignored, and the flags are not disturbed.
- R8: After DEPTH accepted writes with no reads, every stage is occupied. in_ready then stays 0 and out_ready stays 1 for as long as no read occurs.
- R9: With oe=1, dout carries the word held in the last stage. With oe=0, dout is high impedance.
- R10: A read and a write on the same edge both take effect, and the data order and flag behaviour stay the same as for separate operations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears all markers |
| wr_en | input | 1 | Write strobe |
| din | input | WIDTH | Write data |
| in_ready | output | 1 | First stage vacant; a write is accepted |
| rd_en | input | 1 | Read strobe |
| out_ready | output | 1 | Last stage holds a word |
| oe | input | 1 | Output enable for dout; 0 floats the pins |
| dout | output | WIDTH | Word at the output end, or high impedance |

## Verification
The first corner case is the fall-through latency. A chain that let a word skip stages within one edge would raise out_ready earlier than DEPTH-1 edges. A chain that stalls would raise it later. The second is writing against a busy first stage: an implementation that overwrote stage 0 would emit extra or corrupted words in the drain that follows a long fill. The bench also reads from an empty chain, holds a full chain with no reads, resets in mid-operation, and sweeps every pairing of write and read rates against a cycle model and an order queue, so that same-edge read/write collisions and lost or duplicated words show up as miscompares.

// File: rtl/efifo_pkg.sv
package efifo_pkg;
  // Default organisation of the chain
  localparam int unsigned EF_DEPTH_DEF = 16;
  localparam int unsigned EF_WIDTH_DEF = 4;
endpackage

// File: rtl/efifo_stage.sv
// One word position: occupancy marker plus data word.
module efifo_stage #(
  parameter int unsigned WIDTH = efifo_pkg::EF_WIDTH_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,   // take the upstream word this edge
  input  logic             drop_i,   // word leaves downstream this edge
  input  logic [WIDTH-1:0] word_i,
  output logic             full_o,
  output logic [WIDTH-1:0] word_o
);

  logic             mark_q, mark_d;
  logic [WIDTH-1:0] word_q;

  always_comb begin
    mark_d = mark_q;
    if (load_i)      mark_d = 1'b1;
    else if (drop_i) mark_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mark_q <= 1'b0;
    else        mark_q <= mark_d;
  end

  // Data path carries no reset; it is qualified by the marker.
  always_ff @(posedge clk) begin
    if (load_i) word_q <= word_i;
  end

  assign full_o = mark_q;
  assign word_o = word_q;

  // R4: the chain only loads a stage that is vacant
  p_load_vacant_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> !full_o);

  // R4: a loaded word lands intact on the next cycle
  p_load_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (full_o && word_o == $past(word_i)));

  // R5: an occupied stage with no handoff keeps its word
  p_hold_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && !drop_i) |=> (full_o && $stable(word_o)));

  // R6: a stage that hands its word on becomes vacant
  p_drop_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    drop_i |=> !full_o);

endmodule

// File: rtl/efifo_chain.sv
// Ripple chain of stages with local handoff; stage 0 is the input end.
module efifo_chain #(
  parameter int unsigned DEPTH = efifo_pkg::EF_DEPTH_DEF,
  parameter int unsigned WIDTH = efifo_pkg::EF_WIDTH_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] din,
  input  logic             rd_en,
  output logic [DEPTH-1:0] mark_o,
  output logic [WIDTH-1:0] tail_word_o
);

  localparam int unsigned LAST = DEPTH - 1;

  logic [DEPTH-1:0] mark;
  logic [DEPTH-1:0] load;
  logic [DEPTH-1:0] drop;
  logic [WIDTH-1:0] word [DEPTH];

  // Handoff decisions use pre-edge markers only.
  always_comb begin
    load[0] = wr_en & ~mark[0];
    for (int i = 1; i < DEPTH; i++) begin
      load[i] = mark[i-1] & ~mark[i];
    end
    for (int i = 0; i < LAST; i++) begin
      drop[i] = load[i+1];
    end
    drop[LAST] = rd_en & mark[LAST];
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    logic [WIDTH-1:0] src;
    if (g == 0) begin : g_head
      assign src = din;
    end else begin : g_body
      assign src = word[g-1];
    end

    efifo_stage #(.WIDTH(WIDTH)) u_stage (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load[g]),
      .drop_i (drop[g]),
      .word_i (src),
      .full_o (mark[g]),
      .word_o (word[g])
    );
  end

  assign mark_o      = mark;
  assign tail_word_o = word[LAST];

endmodule

// File: rtl/efifo_tri.sv
// Output driver: floats the data pins when not enabled.
module efifo_tri #(
  parameter int unsigned WIDTH = efifo_pkg::EF_WIDTH_DEF
) (
  input  logic             oe,
  input  logic [WIDTH-1:0] word_i,
  output logic [WIDTH-1:0] pad_o
);
  assign pad_o = oe ? word_i : {WIDTH{1'bz}};
endmodule

// File: rtl/elastic_chain_fifo.sv
module elastic_chain_fifo #(
  parameter int unsigned DEPTH = efifo_pkg::EF_DEPTH_DEF,
  parameter int unsigned WIDTH = efifo_pkg::EF_WIDTH_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] din,
  output logic             in_ready,
  input  logic             rd_en,
  output logic             out_ready,
  input  logic             oe,
  output logic [WIDTH-1:0] dout
);

  localparam int unsigned LAST = DEPTH - 1;

  logic [DEPTH-1:0] mark;
  logic [WIDTH-1:0] tail_word;

  efifo_chain #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chain (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .din         (din),
    .rd_en       (rd_en),
    .mark_o      (mark),
    .tail_word_o (tail_word)
  );

  assign in_ready  = ~mark[0];
  assign out_ready = mark[LAST];

  efifo_tri #(.WIDTH(WIDTH)) u_tri (
    .oe     (oe),
    .word_i (tail_word),
    .pad_o  (dout)
  );

  // R2: an accepted write occupies the input stage
  p_write_takes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && in_ready) |=> !in_ready);

  // R3: a write against a blocked input stage leaves it unchanged
  p_busy_write_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !in_ready && mark[1]) |=> !in_ready);

  // R6: a read of the last stage empties it
  p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && out_ready) |=> !out_ready);

  // R7: reading an empty output with nothing arriving changes nothing
  p_empty_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_ready && !mark[LAST-1]) |=> !out_ready);

  // R8: a full chain without reads stays full
  p_full_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((&mark) && !rd_en) |=> ((&mark) && !in_ready && out_ready));

endmodule

// File: tb/tb_elastic_chain_fifo.sv
`timescale 1ns/1ps
module tb_elastic_chain_fifo;

  localparam int D = 6;
  localparam int W = 4;

  logic         clk;
  logic         rst_n;
  logic         wr_en;
  logic [W-1:0] din;
  logic         in_ready;
  logic         rd_en;
  logic         out_ready;
  logic         oe;
  wire  [W-1:0] dout;

  int vectors  = 0;
  int mismatch = 0;

  elastic_chain_fifo #(.DEPTH(D), .WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .din(din), .in_ready(in_ready),
    .rd_en(rd_en), .out_ready(out_ready), .oe(oe), .dout(dout)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      mismatch++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, mismatch);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatch++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  // Cycle model of the markers and words
  logic         mv [D];
  logic [W-1:0] md [D];
  logic [W-1:0] q  [$];

  task automatic model_clear();
    for (int i = 0; i < D; i++) mv[i] = 1'b0;
    q.delete();
  endtask

  initial begin
    int n;
    int both;
    logic [W-1:0] expw;
    wr_en = 0; rd_en = 0; din = '0; oe = 1'b1; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset in_ready", {31'd0, in_ready}, 1);
    chk("R1 reset out_ready", {31'd0, out_ready}, 0);

    // R7: reads on an empty FIFO
    rd_en = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R7 empty read out_ready", {31'd0, out_ready}, 0);
      chk("R7 empty read in_ready", {31'd0, in_ready}, 1);
    end
    rd_en = 1'b0;

    // R2 + R4: single word latency
    wr_en = 1'b1; din = 4'h9;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R2 in_ready after write", {31'd0, in_ready}, 0);
    n = 0;
    while (!out_ready && n < 4*D) begin
      @(negedge clk);
      n++;
    end
    chk("R4 fall-through latency", n, D-1);
    chk("R9 dout with oe=1", {28'd0, dout}, 32'h9);
    oe = 1'b0;
    #1;
    vectors++;
    if (dout === 4'h9) begin
      mismatch++;
      $display("FAIL R9 dout with oe=0 actual=%0h expected=z", dout);
    end
    oe = 1'b1;
    #1;
    chk("R9 word kept across oe", {28'd0, dout}, 32'h9);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk("R6 out_ready after read", {31'd0, out_ready}, 0);
    chk("R6 in_ready after read", {31'd0, in_ready}, 1);

    // R8 + R3: hold the write strobe until full
    q.delete();
    wr_en = 1'b1;
    for (int c = 0; c < 6*D; c++) begin
      din = W'(c + 3);
      if (in_ready) q.push_back(din);
      @(negedge clk);
    end
    wr_en = 1'b0;
    chk("R8 accepted count", q.size(), D);
    chk("R8 full in_ready", {31'd0, in_ready}, 0);
    chk("R8 full out_ready", {31'd0, out_ready}, 1);
    repeat (3) @(negedge clk);
    chk("R8 full holds", {30'd0, in_ready, out_ready}, 32'h1);

    // Drain: R3 (no extra words) and R5 (order)
    rd_en = 1'b1;
    for (int c = 0; c < 8*D; c++) begin
      if (out_ready) begin
        if (q.size() == 0) chk("R3 extra word emitted", 1, 0);
        else begin
          expw = q.pop_front();
          chk("R5 drain order", {28'd0, dout}, {28'd0, expw});
        end
      end
      @(negedge clk);
    end
    rd_en = 1'b0;
    chk("R3 all words drained", q.size(), 0);
    chk("R3 empty after drain", {31'd0, out_ready}, 0);

    // Rate sweep against the cycle model: R2, R5, R6, R10
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    model_clear();
    both = 0;
    for (int wp = 0; wp <= 4; wp++) begin
      for (int rp = 0; rp <= 4; rp++) begin
        for (int c = 0; c < 300; c++) begin
          logic         w, r;
          logic [W-1:0] d;
          logic         nv [D];
          logic [W-1:0] nd [D];
          chk("R2 in_ready vs model", {31'd0, in_ready}, {31'd0, ~mv[0]});
          chk("R6 out_ready vs model", {31'd0, out_ready}, {31'd0, mv[D-1]});
          if (mv[D-1]) chk("R5 dout vs model", {28'd0, dout}, {28'd0, md[D-1]});
          w = ($urandom_range(3) < wp);
          r = ($urandom_range(3) < rp);
          d = W'($urandom_range(15));
          for (int i = 0; i < D; i++) begin nv[i] = mv[i]; nd[i] = md[i]; end
          if (r && mv[D-1]) begin
            nv[D-1] = 1'b0;
            if (q.size() == 0) chk("R5 read with empty queue", 1, 0);
            else begin
              expw = q.pop_front();
              chk("R5 read order", {28'd0, dout}, {28'd0, expw});
            end
          end
          for (int i = 1; i < D; i++) begin
            if (mv[i-1] && !mv[i]) begin
              nv[i] = 1'b1; nd[i] = md[i-1]; nv[i-1] = 1'b0;
            end
          end
          if (w && !mv[0]) begin
            nv[0] = 1'b1; nd[0] = d; q.push_back(d);
            if (r && mv[D-1]) both++;
          end
          wr_en = w; rd_en = r; din = d;
          @(negedge clk);
          for (int i = 0; i < D; i++) begin mv[i] = nv[i]; md[i] = nd[i]; end
        end
      end
    end
    wr_en = 1'b0; rd_en = 1'b0;
    chk("R10 same-edge read and write seen", {31'd0, (both > 0)}, 1);

    // R1: reset in mid-operation, asynchronous assertion
    wr_en = 1'b1; din = 4'h5;
    repeat (2*D) @(negedge clk);
    wr_en = 1'b0;
    #3 rst_n = 1'b0;
    #1;
    chk("R1 mid reset in_ready", {31'd0, in_ready}, 1);
    chk("R1 mid reset out_ready", {31'd0, out_ready}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (D) @(negedge clk);
    chk("R1 stays empty after reset", {30'd0, in_ready, out_ready}, 32'h2);

    summary();
    $finish;
  end

endmodule